// File: doc/BRIEF.md
# HDLC Receive Gate and Frame Length Supervisor

This block sits beside an HDLC receiver and makes two decisions on its behalf. The first is whether the receiver is enabled. When carrier-detect auto start is switched on and the programmed clock mode provides a carrier-detect source, the enable follows a synchronized carrier-detect pin. In every other case it follows a host enable bit. The clock mode decides which pin supplies carrier detect: the auxiliary clock pin in some modes, and the transmit clock pin in others, but the transmit clock pin only when it is configured as an input.

The second decision is frame length supervision. The deserializer presents a byte strobe and frame start and end markers. The block forwards accepted bytes as a write strobe and counts them per frame. When the length check is on and a frame grows past (L+1)×32 bytes, where L is a 7-bit field, the block refuses the first byte beyond the limit. It then raises a one-cycle terminate strobe, sets an overlength status, and drops all bytes until the next frame start.

Top module: `hdlc_rx_guard`

## Requirements
- R1: While reset is asserted and in the first cycle after it, rx_enable, byte_wr, len_abort and overlength are all 0.
- R2: When autostart_en is 0, rx_enable takes the value host_rx_en held before the previous rising edge, which is a one-cycle delay.
- R3: The carrier-detect pins pass through two synchronizer flip-flops. When auto start is active on a supported route, a change on the selected pin appears on rx_enable at the third rising edge after it.
- R4: In clock modes 0, 2 and 3 (clk_mode values 3'd0, 3'd2, 3'd3), with auto start on, carrier detect comes from aux_cd_pin, and txclk_cd_pin has no effect.
- R5: In clock modes 4, 6 and 7, carrier detect comes from txclk_cd_pin only when txclk_is_input is 1. When txclk_is_input is 0, rx_enable follows host_rx_en as in R2.
- R6: Clock modes 1 and 5 have no carrier-detect source. In these modes rx_enable follows host_rx_en even with auto start on.
- R7: byte_wr equals byte_valid while rx_enable is 1 and a frame is open. frame_start opens a frame, and a byte in the same cycle is its first byte. frame_end closes the frame after that cycle's byte is written.
- R8: With lencheck_en at 1 and length field L, the limit is (L+1)×32 bytes. A frame of exactly that length completes without abort. The next byte is not written, len_abort pulses for exactly one cycle in the following cycle, and overlength becomes 1 in that same cycle.
- R9: After a length abort, bytes are dropped until the next frame start. overlength holds until a frame_start arrives while rx_enable is 1, and that frame_start clears it.
- R10: With lencheck_en at 0, frames of any length are written in full and len_abort stays 0.
- R11: Dropping rx_enable closes any open frame. After the receiver is re-enabled, bytes are not written until a new frame_start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_mode | input | 3 | Programmed clock mode 0..7 |
| autostart_en | input | 1 | Carrier-detect auto start enable |
| txclk_is_input | input | 1 | Transmit clock pin configured as input |
| host_rx_en | input | 1 | Host receiver enable |
| aux_cd_pin | input | 1 | Auxiliary clock pin used as carrier detect (asynchronous) |
| txclk_cd_pin | input | 1 | Transmit clock pin used as carrier detect (asynchronous) |
| lencheck_en | input | 1 | Length check enable |
| len_blocks | input | 7 | Length field L, limit (L+1)×32 bytes |
| frame_start | input | 1 | Frame start marker from the deserializer |
| frame_end | input | 1 | Frame end marker from the deserializer |
| byte_valid | input | 1 | Received byte strobe |
| rx_enable | output | 1 | Receiver enable |
| byte_wr | output | 1 | Accepted byte write strobe |
| len_abort | output | 1 | One-cycle terminate strobe on length overrun |
| overlength | output | 1 | Frame exceeded the length limit |

## Verification
The bench steps every clock mode with auto start on, while the two carrier-detect pins toggle out of phase. A design that decodes the wrong pin for a mode, or ignores the input-direction bit, then shows rx_enable in the wrong phase. Frames of exactly 32 and 64 bytes, and frames a few bytes longer, probe the limit. An off-by-one in the (L+1)×32 compare either aborts a legal frame or writes the extra byte. Further cases cover frame_start and frame_end in the same cycle as a byte, disabling the receiver mid-frame, and a frame after an abort. These catch a count that is not reset, a stale drop state, and an overlength status that is not cleared.

// File: rtl/hdlc_rx_guard_pkg.sv
package hdlc_rx_guard_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        CD_NONE  = 2'd0,
        CD_AUX   = 2'd1,
        CD_TXCLK = 2'd2
    } cd_src_e;

    // Which pin, if any, carries carrier detect in a given clock mode.
    function automatic cd_src_e pick_cd_src(input logic [MODE_W-1:0] mode,
                                            input logic               tx_is_in);
        cd_src_e src;
        case (mode)
            3'd0, 3'd2, 3'd3: src = CD_AUX;
            3'd4, 3'd6, 3'd7: src = tx_is_in ? CD_TXCLK : CD_NONE;
            default:          src = CD_NONE;
        endcase
        return src;
    endfunction

endpackage

// File: rtl/hdlc_rx_cd_sync.sv
module hdlc_rx_cd_sync #(
    parameter int N_SRC  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] pin_async,
    output logic [N_SRC-1:0] pin_sync
);

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        logic [STAGES-1:0] pipe_d, pipe_q;

        always_comb begin
            pipe_d = {pipe_q[STAGES-2:0], pin_async[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= '0;
            else        pipe_q <= pipe_d;
        end

        assign pin_sync[g] = pipe_q[STAGES-1];
    end

endmodule

// File: rtl/hdlc_rx_cd_route.sv
module hdlc_rx_cd_route
    import hdlc_rx_guard_pkg::*;
(
    input  logic [MODE_W-1:0] clk_mode,
    input  logic              txclk_is_input,
    input  logic              autostart_en,
    input  logic              aux_cd,
    input  logic              txclk_cd,
    output logic              use_cd,
    output logic              cd_level
);

    cd_src_e src;

    always_comb begin
        src      = pick_cd_src(clk_mode, txclk_is_input);
        use_cd   = autostart_en && (src != CD_NONE);
        cd_level = 1'b0;
        case (src)
            CD_AUX:   cd_level = aux_cd;
            CD_TXCLK: cd_level = txclk_cd;
            default:  cd_level = 1'b0;
        endcase
    end

endmodule

// File: rtl/hdlc_rx_len_track.sv
module hdlc_rx_len_track #(
    parameter int unsigned LEN_W     = 7,
    parameter int unsigned BLK_BYTES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_en,
    input  logic             lencheck_en,
    input  logic [LEN_W-1:0] len_blocks,
    input  logic             frame_start,
    input  logic             frame_end,
    input  logic             byte_valid,
    output logic             byte_wr,
    output logic             len_abort,
    output logic             overlength
);

    localparam int unsigned MAX_LIMIT = (2 ** LEN_W) * BLK_BYTES;
    localparam int unsigned CNT_W     = $clog2(MAX_LIMIT + 1);

    typedef struct packed {
        logic             in_frame;
        logic [CNT_W-1:0] cnt;
        logic             ovl;
        logic             abort;
    } len_state_t;

    len_state_t       st_d, st_q;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt_eff;
    logic             in_eff;
    logic             hit;
    logic             wr;

    always_comb begin
        limit   = CNT_W'((32'(len_blocks) + 32'd1) * BLK_BYTES);
        in_eff  = rx_en && (frame_start || st_q.in_frame);
        cnt_eff = frame_start ? '0 : st_q.cnt;
        hit     = in_eff && byte_valid && lencheck_en && (cnt_eff == limit);
        wr      = in_eff && byte_valid && !hit;

        st_d          = st_q;
        st_d.in_frame = in_eff && !frame_end && !hit;
        st_d.cnt      = cnt_eff;
        if (wr && (cnt_eff != '1)) st_d.cnt = cnt_eff + 1'b1;
        st_d.ovl      = hit || (st_q.ovl && !(rx_en && frame_start));
        st_d.abort    = hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign byte_wr    = wr;
    assign len_abort  = st_q.abort;
    assign overlength = st_q.ovl;

endmodule

// File: rtl/hdlc_rx_guard.sv
module hdlc_rx_guard
    import hdlc_rx_guard_pkg::*;
#(
    parameter int unsigned LEN_W     = 7,
    parameter int unsigned BLK_BYTES = 32,
    parameter int          CD_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] clk_mode,
    input  logic              autostart_en,
    input  logic              txclk_is_input,
    input  logic              host_rx_en,
    input  logic              aux_cd_pin,
    input  logic              txclk_cd_pin,
    input  logic              lencheck_en,
    input  logic [LEN_W-1:0]  len_blocks,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic              byte_valid,
    output logic              rx_enable,
    output logic              byte_wr,
    output logic              len_abort,
    output logic              overlength
);

    typedef struct packed {
        logic rx_en;
    } gate_state_t;

    gate_state_t g_d, g_q;
    logic [1:0]  cd_sync;
    logic        use_cd;
    logic        cd_level;

    hdlc_rx_cd_sync #(
        .N_SRC  (2),
        .STAGES (CD_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async ({txclk_cd_pin, aux_cd_pin}),
        .pin_sync  (cd_sync)
    );

    hdlc_rx_cd_route u_route (
        .clk_mode       (clk_mode),
        .txclk_is_input (txclk_is_input),
        .autostart_en   (autostart_en),
        .aux_cd         (cd_sync[0]),
        .txclk_cd       (cd_sync[1]),
        .use_cd         (use_cd),
        .cd_level       (cd_level)
    );

    always_comb begin
        g_d       = g_q;
        g_d.rx_en = use_cd ? cd_level : host_rx_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign rx_enable = g_q.rx_en;

    hdlc_rx_len_track #(
        .LEN_W     (LEN_W),
        .BLK_BYTES (BLK_BYTES)
    ) u_len (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_en       (g_q.rx_en),
        .lencheck_en (lencheck_en),
        .len_blocks  (len_blocks),
        .frame_start (frame_start),
        .frame_end   (frame_end),
        .byte_valid  (byte_valid),
        .byte_wr     (byte_wr),
        .len_abort   (len_abort),
        .overlength  (overlength)
    );

endmodule

// File: rtl/hdlc_rx_guard_chk.sv
module hdlc_rx_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] clk_mode,
    input logic       autostart_en,
    input logic       host_rx_en,
    input logic       lencheck_en,
    input logic       frame_start,
    input logic       byte_valid,
    input logic       rx_enable,
    input logic       byte_wr,
    input logic       len_abort,
    input logic       overlength
);

    p_host_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !autostart_en |=> (rx_enable == $past(host_rx_en)));

    p_mode1_host_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_mode == 3'd1) |=> (rx_enable == $past(host_rx_en)));

    p_wr_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        byte_wr |-> (rx_enable && byte_valid));

    p_abort_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        len_abort |=> !len_abort);

    p_abort_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
        len_abort |-> overlength);

    p_ovl_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (overlength && !(frame_start && rx_enable)) |=> overlength);

    p_no_check_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !lencheck_en |=> !len_abort);

endmodule

bind hdlc_rx_guard hdlc_rx_guard_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_mode     (clk_mode),
    .autostart_en (autostart_en),
    .host_rx_en   (host_rx_en),
    .lencheck_en  (lencheck_en),
    .frame_start  (frame_start),
    .byte_valid   (byte_valid),
    .rx_enable    (rx_enable),
    .byte_wr      (byte_wr),
    .len_abort    (len_abort),
    .overlength   (overlength)
);

// File: tb/hdlc_rx_guard_test.sv
module hdlc_rx_guard_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] clk_mode = 3'd0;
    logic       autostart_en = 1'b0, txclk_is_input = 1'b0, host_rx_en = 1'b0;
    logic       aux_cd_pin = 1'b0, txclk_cd_pin = 1'b0, lencheck_en = 1'b0;
    logic [6:0] len_blocks = 7'd0;
    logic       frame_start = 1'b0, frame_end = 1'b0, byte_valid = 1'b0;
    logic       rx_enable, byte_wr, len_abort, overlength;

    int checks = 0;
    int fails  = 0;

    // reference model state
    int m_aux1, m_aux2, m_tx1, m_tx2;
    int m_rx, m_in, m_cnt, m_ovl, m_abort;
    int e_wr, e_hit, e_in_eff, e_cnt_eff;

    always #(CLK_PERIOD/2) clk = ~clk;

    hdlc_rx_guard uut (
        .clk(clk), .rst_n(rst_n), .clk_mode(clk_mode), .autostart_en(autostart_en),
        .txclk_is_input(txclk_is_input), .host_rx_en(host_rx_en),
        .aux_cd_pin(aux_cd_pin), .txclk_cd_pin(txclk_cd_pin),
        .lencheck_en(lencheck_en), .len_blocks(len_blocks),
        .frame_start(frame_start), .frame_end(frame_end), .byte_valid(byte_valid),
        .rx_enable(rx_enable), .byte_wr(byte_wr), .len_abort(len_abort),
        .overlength(overlength)
    );

    task automatic model_reset();
        m_aux1 = 0; m_aux2 = 0; m_tx1 = 0; m_tx2 = 0;
        m_rx = 0; m_in = 0; m_cnt = 0; m_ovl = 0; m_abort = 0;
    endtask

    task automatic model_comb();
        int limit;
        limit     = (int'(len_blocks) + 1) * 32;
        e_in_eff  = (m_rx != 0 && (frame_start || m_in != 0)) ? 1 : 0;
        e_cnt_eff = frame_start ? 0 : m_cnt;
        e_hit     = (e_in_eff != 0 && byte_valid && lencheck_en && e_cnt_eff == limit) ? 1 : 0;
        e_wr      = (e_in_eff != 0 && byte_valid && e_hit == 0) ? 1 : 0;
    endtask

    task automatic model_edge();
        int use_cd, lvl, nrx;
        use_cd = 0; lvl = 0;
        if (autostart_en) begin
            if (clk_mode == 3'd0 || clk_mode == 3'd2 || clk_mode == 3'd3) begin
                use_cd = 1; lvl = m_aux2;
            end else if ((clk_mode == 3'd4 || clk_mode == 3'd6 || clk_mode == 3'd7) && txclk_is_input) begin
                use_cd = 1; lvl = m_tx2;
            end
        end
        nrx = use_cd ? lvl : int'(host_rx_en);
        if (m_rx != 0 && frame_start) m_ovl = 0;
        if (e_hit != 0) m_ovl = 1;
        m_abort = e_hit;
        m_in  = (e_in_eff != 0 && !frame_end && e_hit == 0) ? 1 : 0;
        m_cnt = (e_wr != 0 && e_cnt_eff < 8191) ? e_cnt_eff + 1 : e_cnt_eff;
        m_rx  = nrx;
        m_aux2 = m_aux1; m_aux1 = int'(aux_cd_pin);
        m_tx2  = m_tx1;  m_tx1  = int'(txclk_cd_pin);
    endtask

    task automatic check1(input string req, input string name, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s at %0t: actual %0d expected %0d", req, name, $time, act, exp);
        end
    endtask

    // Called just after a negedge with inputs applied; leaves at the next negedge.
    task automatic tick(input string req);
        #1;
        model_comb();
        check1(req, "rx_enable",  int'(rx_enable),  m_rx);
        check1(req, "byte_wr",    int'(byte_wr),    e_wr);
        check1(req, "len_abort",  int'(len_abort),  m_abort);
        check1(req, "overlength", int'(overlength), m_ovl);
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            frame_start = 0; frame_end = 0; byte_valid = 0;
            tick(req);
        end
    endtask

    task automatic run_frame(input int nbytes, input string req);
        for (int i = 0; i < nbytes; i++) begin
            if (i % 4 == 3) begin
                frame_start = 0; frame_end = 0; byte_valid = 0;
                tick(req);
            end
            byte_valid  = 1;
            frame_start = (i == 0);
            frame_end   = (i == nbytes - 1);
            tick(req);
        end
        idle(3, req);
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        $display("FAIL watchdog expired at %0t", $time);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // R1: outputs during reset
        check1("R1", "rx_enable",  int'(rx_enable), 0);
        check1("R1", "byte_wr",    int'(byte_wr), 0);
        check1("R1", "len_abort",  int'(len_abort), 0);
        check1("R1", "overlength", int'(overlength), 0);
        rst_n = 1;
        model_reset();
        tick("R1");

        // R2: host enable path
        for (int i = 0; i < 12; i++) begin
            host_rx_en = (i % 3 != 0);
            aux_cd_pin = (i % 2 == 0);
            tick("R2");
        end

        // R3 / R4 / R5 / R6: auto start over every mode, pins toggling out of phase
        autostart_en = 1;
        for (int tin = 0; tin < 2; tin++) begin
            txclk_is_input = (tin == 1);
            for (int md = 0; md < 8; md++) begin
                clk_mode = 3'(md);
                for (int i = 0; i < 16; i++) begin
                    aux_cd_pin   = ((i / 3) % 2 == 0);
                    txclk_cd_pin = ((i / 3) % 2 == 1);
                    host_rx_en   = ((i / 5) % 2 == 0);
                    if (md == 1 || md == 5) tick("R6");
                    else if (md >= 4)       tick("R5");
                    else if (i < 4)         tick("R3");
                    else                    tick("R4");
                end
            end
        end

        // framing under host enable
        autostart_en = 0; host_rx_en = 1; aux_cd_pin = 0; txclk_cd_pin = 0;
        lencheck_en = 1; len_blocks = 7'd0;
        idle(2, "R7");
        run_frame(10, "R7");
        run_frame(1, "R7");        // start and end with the same byte
        run_frame(32, "R8");       // exactly at the limit
        run_frame(40, "R8");       // overrun by eight
        idle(2, "R9");
        run_frame(5, "R9");        // new frame clears status
        len_blocks = 7'd1;
        run_frame(64, "R8");
        run_frame(66, "R8");
        lencheck_en = 0; len_blocks = 7'd0;
        run_frame(100, "R10");

        // R11: disable mid-frame, then bytes without a new start
        lencheck_en = 1;
        byte_valid = 1; frame_start = 1; tick("R11");
        frame_start = 0;
        for (int i = 0; i < 4; i++) tick("R11");
        host_rx_en = 0;
        for (int i = 0; i < 4; i++) tick("R11");
        host_rx_en = 1;
        for (int i = 0; i < 5; i++) tick("R11");
        frame_start = 1; tick("R11");
        frame_start = 0; frame_end = 1; tick("R11");
        idle(3, "R11");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule